// File: doc/BRIEF.md
# Timer Compare Interrupt Flag Controller

This block gathers the compare-match events from a bank of timers. Each timer has two events, compare A and compare B. For every event it keeps a latched flag, an interrupt enable bit and a DMA-steering bit. Software reaches these through byte-wide registers, each covering two neighbouring timers. A single priority field per timer pair sets how urgent that pair's requests are.

Software can write the flags in two ways. In the default clear-only method, writing 1 clears a flag. In the direct method, the written value replaces the flag. The block raises a single CPU interrupt request that takes into account the enables, a global interrupt-enable input, a higher-priority-pending input and a strict comparison of priority against the current CPU level.

An event can be steered to a DMA channel instead. It then raises a DMA request that stays up until the matching done pulse arrives. Only after that pulse may the flag reach the CPU. Flags, DMA requests and enables are plain level signals. There is no streaming data path, so no valid/ready handshake applies.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: A compare event sets its flag on the next clock edge, whatever the enable, priority and DMA settings are.
- R2: After reset, all enable, flag, DMA-steering and priority registers read 0, and `irq_req` and `dma_req` are 0.
- R3: `reg_addr[4:3]` selects the register kind: 0 = enable, 1 = flag, 2 = DMA steering, 3 = priority. `reg_addr[2:0]` selects the timer pair p, which covers timers 2p and 2p+1. In kinds 0 to 2 the bits are: bit 2 = even timer compare B, bit 3 = even timer compare A, bit 6 = odd timer compare B, bit 7 = odd timer compare A. Bits 0, 1, 4 and 5 read 0 and ignore writes. In kind 3, bits [2:0] hold the priority and bits [7:3] read 0.
- R4: With `flag_mode` = 0, writing 1 to a flag bit clears it and writing 0 leaves it unchanged.
- R5: With `flag_mode` = 1, each written flag bit takes the written value, 1 or 0.
- R6: When a compare event and a write that would clear the same flag arrive in the same cycle, the flag is set after the edge.
- R7: `irq_req` is 1 exactly when `cpu_ie` = 1, `higher_pending` = 0, and some event has its flag = 1, its enable = 1, no pending DMA request, and a pair priority strictly greater than `cpu_level`. It follows from registered state and inputs without an extra cycle of delay.
- R8: An event whose DMA-steering bit is 1 raises `dma_req[2t+k]` on the next edge, where t is the timer and k = 0 for compare A and 1 for compare B. While that request is pending, the event adds nothing to `irq_req`.
- R9: A pending DMA request stays at 1 until `dma_done` is pulsed for that bit. After the pulse the request drops, and the event may raise `irq_req` under the rules of R7.
- R10: Pair indexes 5 to 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_a_evt | input | 10 | Compare A event pulse, one per timer |
| cmp_b_evt | input | 10 | Compare B event pulse, one per timer |
| flag_mode | input | 1 | Flag write method: 0 = clear-only, 1 = direct |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register kind [4:3] and pair index [2:0] |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cpu_ie | input | 1 | Global interrupt enable |
| cpu_level | input | 3 | Current CPU interrupt level |
| higher_pending | input | 1 | A higher-priority request is pending elsewhere |
| dma_done | input | 20 | Per-event DMA completion pulse |
| dma_req | output | 20 | Per-event pending DMA request |
| irq_req | output | 1 | CPU interrupt request |

## Verification
The bench aims at the write methods. If the modes are swapped, or if a 0 written in clear-only mode clears a flag, the flag readbacks come out wrong. It forces a compare event to coincide with a clearing write: a design that lets the write win leaves the flag at 0. It checks priority equal to the level, where a non-strict comparison would raise the interrupt. It also checks `cpu_ie`, `higher_pending` and the enable bit, each removed on its own, so an ungated request shows up. In the DMA path it checks that the CPU request stays low while the DMA request is held over several cycles, and that the request rises only after the done pulse. A design that does not suppress, or that drops the request early, is caught there.

// File: rtl/tifc_pkg.sv
package tifc_pkg;
  typedef enum logic [1:0] {
    KIND_EN   = 2'd0,
    KIND_FLAG = 2'd1,
    KIND_DMA  = 2'd2,
    KIND_PRIO = 2'd3
  } reg_kind_e;

  // Event index f = 2*timer + (0 for compare A, 1 for compare B)
  function automatic int unsigned bit_of(input int unsigned f);
    int unsigned base;
    base = ((f / 2) % 2 == 1) ? 4 : 0;
    return base + ((f % 2 == 1) ? 2 : 3);
  endfunction

  function automatic int unsigned pair_of(input int unsigned f);
    return f / 4;
  endfunction
endpackage

// File: rtl/tifc_factor_cell.sv
module tifc_factor_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic flag_mode,
  input  logic we_en,
  input  logic we_flag,
  input  logic we_dma,
  input  logic wbit,
  input  logic dma_done,
  output logic flag_q,
  output logic en_q,
  output logic dmaen_q,
  output logic pend_q
);
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (evt)
      flag_d = 1'b1;
    else if (we_flag)
      flag_d = flag_mode ? wbit : (flag_q & ~wbit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      en_q    <= 1'b0;
      dmaen_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (we_en)  en_q    <= wbit;
      if (we_dma) dmaen_q <= wbit;
      if (evt && dmaen_q) pend_q <= 1'b1;
      else if (dma_done)  pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tifc_bus_decode.sv
module tifc_bus_decode
  import tifc_pkg::*;
#(
  parameter int NF     = 20,
  parameter int NP     = 5,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 5
) (
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [7:0]           reg_wdata,
  input  logic [NF-1:0]        en_q,
  input  logic [NF-1:0]        flag_q,
  input  logic [NF-1:0]        dmaen_q,
  input  logic [NP*PRIO_W-1:0] prio_q,
  output logic [NF-1:0]        we_en,
  output logic [NF-1:0]        we_flag,
  output logic [NF-1:0]        we_dma,
  output logic [NF-1:0]        wbit,
  output logic [NP-1:0]        we_prio,
  output logic [7:0]           reg_rdata
);
  localparam int PAIR_W = ADDR_W - 2;
  localparam logic [PAIR_W:0] NP_L = (PAIR_W+1)'(NP);

  reg_kind_e         kind;
  logic [PAIR_W-1:0] pair;
  logic              in_range;

  assign kind     = reg_kind_e'(reg_addr[ADDR_W-1 -: 2]);
  assign pair     = reg_addr[PAIR_W-1:0];
  assign in_range = ({1'b0, pair} < NP_L);

  for (genvar f = 0; f < NF; f++) begin : g_fw
    localparam int unsigned BP = bit_of(f);
    localparam int unsigned PP = pair_of(f);
    logic hit;
    assign hit        = reg_wr && in_range && (pair == PAIR_W'(PP));
    assign we_en[f]   = hit && (kind == KIND_EN);
    assign we_flag[f] = hit && (kind == KIND_FLAG);
    assign we_dma[f]  = hit && (kind == KIND_DMA);
    assign wbit[f]    = reg_wdata[BP];
  end

  for (genvar p = 0; p < NP; p++) begin : g_pw
    assign we_prio[p] = reg_wr && in_range && (pair == PAIR_W'(p)) && (kind == KIND_PRIO);
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (in_range) begin
      if (kind == KIND_PRIO) begin
        for (int p = 0; p < NP; p++)
          if (pair == PAIR_W'(p))
            reg_rdata[PRIO_W-1:0] = prio_q[p*PRIO_W +: PRIO_W];
      end else begin
        for (int f = 0; f < NF; f++) begin
          if (pair == PAIR_W'(pair_of(f))) begin
            case (kind)
              KIND_EN:   reg_rdata[bit_of(f)] = en_q[f];
              KIND_FLAG: reg_rdata[bit_of(f)] = flag_q[f];
              default:   reg_rdata[bit_of(f)] = dmaen_q[f];
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/tifc_req_gate.sv
module tifc_req_gate
  import tifc_pkg::*;
#(
  parameter int NF     = 20,
  parameter int NP     = 5,
  parameter int PRIO_W = 3
) (
  input  logic [NF-1:0]        flag_q,
  input  logic [NF-1:0]        en_q,
  input  logic [NF-1:0]        pend_q,
  input  logic [NP*PRIO_W-1:0] prio_q,
  input  logic [PRIO_W-1:0]    cpu_level,
  input  logic                 cpu_ie,
  input  logic                 higher_pending,
  output logic                 irq_req
);
  logic [NP-1:0] pair_ok;
  logic [NF-1:0] elig;

  for (genvar p = 0; p < NP; p++) begin : g_pp
    assign pair_ok[p] = prio_q[p*PRIO_W +: PRIO_W] > cpu_level;
  end

  for (genvar f = 0; f < NF; f++) begin : g_el
    assign elig[f] = flag_q[f] & en_q[f] & ~pend_q[f] & pair_ok[pair_of(f)];
  end

  assign irq_req = cpu_ie & ~higher_pending & (|elig);
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int NUM_TIMERS = 10,
  parameter int PRIO_W     = 3,
  parameter int ADDR_W     = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_TIMERS-1:0]   cmp_a_evt,
  input  logic [NUM_TIMERS-1:0]   cmp_b_evt,
  input  logic                    flag_mode,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [7:0]              reg_wdata,
  output logic [7:0]              reg_rdata,
  input  logic                    cpu_ie,
  input  logic [PRIO_W-1:0]       cpu_level,
  input  logic                    higher_pending,
  input  logic [2*NUM_TIMERS-1:0] dma_done,
  output logic [2*NUM_TIMERS-1:0] dma_req,
  output logic                    irq_req
);
  localparam int NF = 2 * NUM_TIMERS;
  localparam int NP = (NUM_TIMERS + 1) / 2;

  logic [NF-1:0]        flag_q, en_q, dmaen_q, pend_q;
  logic [NF-1:0]        we_en, we_flag, we_dma, wbit;
  logic [NP-1:0]        we_prio;
  logic [NP*PRIO_W-1:0] prio_q;

  tifc_bus_decode #(.NF(NF), .NP(NP), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_dec (
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .en_q(en_q), .flag_q(flag_q), .dmaen_q(dmaen_q), .prio_q(prio_q),
    .we_en(we_en), .we_flag(we_flag), .we_dma(we_dma), .wbit(wbit),
    .we_prio(we_prio), .reg_rdata(reg_rdata)
  );

  for (genvar f = 0; f < NF; f++) begin : g_cell
    logic evt;
    if (f % 2 == 0) begin : g_a
      assign evt = cmp_a_evt[f/2];
    end else begin : g_b
      assign evt = cmp_b_evt[f/2];
    end
    tifc_factor_cell u_cell (
      .clk(clk), .rst_n(rst_n), .evt(evt), .flag_mode(flag_mode),
      .we_en(we_en[f]), .we_flag(we_flag[f]), .we_dma(we_dma[f]),
      .wbit(wbit[f]), .dma_done(dma_done[f]),
      .flag_q(flag_q[f]), .en_q(en_q[f]), .dmaen_q(dmaen_q[f]), .pend_q(pend_q[f])
    );
  end

  for (genvar p = 0; p < NP; p++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          prio_q[p*PRIO_W +: PRIO_W] <= '0;
      else if (we_prio[p]) prio_q[p*PRIO_W +: PRIO_W] <= reg_wdata[PRIO_W-1:0];
    end
  end

  tifc_req_gate #(.NF(NF), .NP(NP), .PRIO_W(PRIO_W)) u_gate (
    .flag_q(flag_q), .en_q(en_q), .pend_q(pend_q), .prio_q(prio_q),
    .cpu_level(cpu_level), .cpu_ie(cpu_ie), .higher_pending(higher_pending),
    .irq_req(irq_req)
  );

  assign dma_req = pend_q;
endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
module tmr_irq_ctrl_chk #(
  parameter int NUM_TIMERS = 10,
  parameter int ADDR_W     = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_TIMERS-1:0]   cmp_a_evt,
  input logic [NUM_TIMERS-1:0]   cmp_b_evt,
  input logic [2*NUM_TIMERS-1:0] flag_q,
  input logic [2*NUM_TIMERS-1:0] en_q,
  input logic [2*NUM_TIMERS-1:0] dma_req,
  input logic [2*NUM_TIMERS-1:0] dma_done,
  input logic                    irq_req,
  input logic                    cpu_ie,
  input logic                    higher_pending,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic [7:0]              reg_rdata
);
  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_t
    // R1 and R6: an event always leaves its flag set
    p_evt_a_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_a_evt[t] |=> flag_q[2*t]);
    p_evt_b_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_b_evt[t] |=> flag_q[2*t+1]);
  end

  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (cpu_ie && !higher_pending && (|(flag_q & en_q))));

  p_dma_blocks_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (|(flag_q & en_q & ~dma_req)));

  p_dma_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dma_req & $past(dma_req & ~dma_done)) == $past(dma_req & ~dma_done)));

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[ADDR_W-1 -: 2] != 2'd3) |-> (reg_rdata[1:0] == 2'b00 && reg_rdata[5:4] == 2'b00));
endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk #(.NUM_TIMERS(NUM_TIMERS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_a_evt(cmp_a_evt), .cmp_b_evt(cmp_b_evt),
  .flag_q(flag_q), .en_q(en_q), .dma_req(dma_req), .dma_done(dma_done),
  .irq_req(irq_req), .cpu_ie(cpu_ie), .higher_pending(higher_pending),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/tmr_irq_ctrl_test.sv
module tmr_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  cmp_a_evt = '0, cmp_b_evt = '0;
  logic        flag_mode = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        cpu_ie = 1'b0;
  logic [2:0]  cpu_level = '0;
  logic        higher_pending = 1'b0;
  logic [19:0] dma_done = '0;
  logic [19:0] dma_req;
  logic        irq_req;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  tmr_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmp_a_evt(cmp_a_evt), .cmp_b_evt(cmp_b_evt),
    .flag_mode(flag_mode), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_ie(cpu_ie),
    .cpu_level(cpu_level), .higher_pending(higher_pending),
    .dma_done(dma_done), .dma_req(dma_req), .irq_req(irq_req)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int kind, input int pair, input logic [7:0] d);
    reg_addr = {2'(kind), 3'(pair)}; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input int kind, input int pair, input logic [7:0] exp);
    reg_addr = {2'(kind), 3'(pair)};
    #1;
    check(req, {24'd0, reg_rdata}, {24'd0, exp});
  endtask

  task automatic t_reset();
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 5; p++) rd("R2 reg zero", k, p, 8'h00);
    check("R2 irq_req", {31'd0, irq_req}, 32'd0);
    check("R2 dma_req", {12'd0, dma_req}, 32'd0);
  endtask

  task automatic t_layout();
    wr(0, 1, 8'hFF);
    rd("R3 enable reserved bits", 0, 1, 8'hCC);
    wr(3, 1, 8'hFF);
    rd("R3 priority width", 3, 1, 8'h07);
    wr(0, 5, 8'hFF);
    rd("R10 unmapped reads 0", 0, 5, 8'h00);
    rd("R10 pair0 untouched", 0, 0, 8'h00);
    wr(3, 7, 8'hFF);
    rd("R10 prio pair0 untouched", 3, 0, 8'h00);
  endtask

  task automatic t_event();
    cmp_a_evt[3] = 1'b1; tick(); cmp_a_evt = '0;
    rd("R1 odd A at bit7", 1, 1, 8'h80);
    cmp_b_evt[0] = 1'b1; tick(); cmp_b_evt = '0;
    rd("R1 flag set with enable 0", 1, 0, 8'h04);
  endtask

  task automatic t_reset_only();
    flag_mode = 1'b0;
    wr(1, 1, 8'h00);
    rd("R4 write 0 no effect", 1, 1, 8'h80);
    wr(1, 1, 8'h80);
    rd("R4 write 1 clears", 1, 1, 8'h00);
    wr(1, 0, 8'h04);
    rd("R4 clear pair0", 1, 0, 8'h00);
  endtask

  task automatic t_rw();
    flag_mode = 1'b1;
    wr(1, 2, 8'h48);
    rd("R5 write 1 sets", 1, 2, 8'h48);
    wr(1, 2, 8'h08);
    rd("R5 write 0 clears", 1, 2, 8'h08);
  endtask

  task automatic t_collide();
    flag_mode = 1'b0;
    reg_addr = {2'd1, 3'd2}; reg_wdata = 8'h08; reg_wr = 1'b1; cmp_a_evt[4] = 1'b1;
    tick();
    reg_wr = 1'b0; cmp_a_evt = '0;
    rd("R6 event beats clear-only write", 1, 2, 8'h08);
    flag_mode = 1'b1;
    reg_addr = {2'd1, 3'd2}; reg_wdata = 8'h00; reg_wr = 1'b1; cmp_a_evt[4] = 1'b1;
    tick();
    reg_wr = 1'b0; cmp_a_evt = '0;
    rd("R6 event beats direct write", 1, 2, 8'h08);
    wr(1, 2, 8'h00);
    flag_mode = 1'b0;
  endtask

  task automatic t_irq();
    cpu_ie = 1'b1; cpu_level = 3'd6; higher_pending = 1'b0;
    cmp_a_evt[2] = 1'b1; tick(); cmp_a_evt = '0;
    check("R7 irq raised", {31'd0, irq_req}, 32'd1);
    cpu_level = 3'd7; #1;
    check("R7 strict priority", {31'd0, irq_req}, 32'd0);
    cpu_level = 3'd6; higher_pending = 1'b1; #1;
    check("R7 higher pending", {31'd0, irq_req}, 32'd0);
    higher_pending = 1'b0; cpu_ie = 1'b0; #1;
    check("R7 ie off", {31'd0, irq_req}, 32'd0);
    cpu_ie = 1'b1;
    wr(0, 1, 8'h00);
    check("R7 enable off", {31'd0, irq_req}, 32'd0);
    wr(1, 1, 8'h08);
    rd("R4 flag cleared", 1, 1, 8'h00);
  endtask

  task automatic t_dma();
    wr(2, 0, 8'h08);
    wr(0, 0, 8'h08);
    wr(3, 0, 8'h03);
    cpu_level = 3'd0; cpu_ie = 1'b1;
    cmp_a_evt[0] = 1'b1; tick(); cmp_a_evt = '0;
    check("R8 dma_req raised", {12'd0, dma_req}, 32'h1);
    check("R8 irq held off", {31'd0, irq_req}, 32'd0);
    rd("R1 flag with dma", 1, 0, 8'h08);
    tick(); tick(); tick();
    check("R9 dma_req held", {12'd0, dma_req}, 32'h1);
    check("R9 irq still off", {31'd0, irq_req}, 32'd0);
    dma_done[0] = 1'b1; tick(); dma_done = '0;
    check("R9 dma_req dropped", {12'd0, dma_req}, 32'h0);
    check("R9 irq after done", {31'd0, irq_req}, 32'd1);
    wr(1, 0, 8'h08);
    check("R4 clear drops irq", {31'd0, irq_req}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_layout();
    t_event();
    t_reset_only();
    t_rw();
    t_collide();
    t_irq();
    t_dma();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule